// File: doc/BRIEF.md
# Processor Power-On Reset Entry Controller

This block decides when a processor core enters power-on reset and supplies the architectural state the core must hold when it leaves that reset. It watches two board pins, an active-low reset pin and a mode-select pin. Each pin passes through a synchroniser before it is decoded. The block also watches a one-cycle overflow pulse from the watchdog timer, together with the watchdog's mode bit and its reset-type bit. The cause logic then classifies the condition as power-on, manual, or none.

While a power-on reset is active, the block holds fetch off and asserts an initialise request to the peripheral modules. When the request goes away, it holds reset for one more cycle and loads the reset values of these registers:
- the exception event register,
- the vector base register,
- the status register,
- the program counter.

It then pulses a completion strobe and opens instruction fetch at the uncached reset vector.

Manual reset is only recognised, not serviced. Manual reset is reported on its own output, and it stops fetch until the next power-on entry. The block also flags a pin sequence that it does not support: the mode pin falling while the reset pin is still low during a power-on reset.

Top module: `rst_entry_ctrl`

## Requirements
- R1: Each pin passes through two synchronising flops. A pin change driven between clock edges first changes the reset state at the third rising edge after it.
- R2: A power-on reset is active while the synchronised reset pin is low and the synchronised mode pin is high. `reset_active_o` is 1 during that time.
- R3: A watchdog overflow pulse causes a power-on reset only when `wdt_mode` is 1 and `wdt_rst_sel` is 0. With `wdt_mode` at 0 the pulse has no effect. With `wdt_mode` at 1 and `wdt_rst_sel` at 1 the pulse is a manual condition.
- R4: A manual condition is the reset pin low with the mode pin low, or a manual watchdog overflow. It raises `man_rst_o`, leaves `reset_active_o` at 0, and clears `fetch_en_o`.
- R5: When a power-on condition and a manual condition are present in the same cycle, power-on reset is taken and `man_rst_o` stays 0.
- R6: After the power-on request goes away, `reset_active_o` stays 1 for exactly one more cycle.
- R7: The entry loads these values:
  - exception event register: 0x0000_0000
  - vector base register: 0x0000_0000
  - program counter: 0xA000_0000
- R8: On entry the packed status word `sr_o` takes these values, which gives 0x7000_00F0:
  - privilege mode, bit 30: 1
  - register bank, bit 29: 1
  - block, bit 28: 1
  - FPU disable, bit 15: 0
  - interrupt mask, bits 7:4: 4'b1111
- R9: `reset_done_o` is a one-cycle pulse in the cycle right after the hold cycle. In that cycle the R7 and R8 values are already present on the outputs.
- R10: `fetch_en_o` is 0 while any reset is active. It rises only in the cycle after `reset_done_o`.
- R11: `periph_init_o` is 1 for every cycle of `reset_active_o` and for one cycle after it.
- R12: `unsup_seq_o` is set when a power-on reset ends with the manual pin combination present. It stays set until the next entry into power-on reset.
- R13: While `rst_n` is low, the outputs are as follows:
  - `reset_active_o` is 1.
  - `fetch_en_o` is 0.
  - the loaded-state outputs are zero.
  
  After `rst_n` is released, the block completes one power-on entry by itself.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Asynchronous active-low reset of the controller's own flops |
| rst_pin_n | input | 1 | Asynchronous reset pin, active low |
| md_pin | input | 1 | Asynchronous mode-select pin |
| wdt_ovf | input | 1 | Watchdog overflow, one-cycle pulse synchronous to clk |
| wdt_mode | input | 1 | Watchdog mode bit (1 = watchdog, 0 = interval) |
| wdt_rst_sel | input | 1 | Watchdog reset type (0 = power-on, 1 = manual) |
| expevt_o | output | 32 | Exception event register value |
| vbr_o | output | 32 | Vector base register value |
| sr_o | output | 32 | Packed status register value |
| pc_o | output | 32 | Program counter value |
| reset_active_o | output | 1 | Power-on reset in progress (including the hold cycle) |
| periph_init_o | output | 1 | Initialise request to the peripheral modules |
| reset_done_o | output | 1 | One-cycle strobe when the loaded state is valid |
| fetch_en_o | output | 1 | Instruction fetch permitted at `pc_o` |
| man_rst_o | output | 1 | Manual reset condition recognised |
| unsup_seq_o | output | 1 | Unsupported pin sequence seen during power-on reset |

## Verification
The assertions assume three things about the inputs:
- `wdt_ovf` is a clean pulse synchronous to `clk`.
- `wdt_mode` and `wdt_rst_sel` are stable whenever a pulse is present.
- The pins may change at any time but only take effect through the synchronisers.

The stimulus drives every input half a cycle away from the sampling edge. It sets the watchdog control bits before raising the overflow pulse, and it keeps each pin level for several cycles. The one exception is the deliberate case of a mode pin falling inside a power-on reset.

// File: rtl/rst_entry_pkg.sv
package rst_entry_pkg;

    typedef enum logic [2:0] {
        ST_RUN  = 3'd0,
        ST_POR  = 3'd1,
        ST_LOAD = 3'd2,
        ST_DONE = 3'd3,
        ST_MAN  = 3'd4
    } rst_state_e;

    typedef struct packed {
        logic       md;
        logic       rb;
        logic       bl;
        logic       fd;
        logic [3:0] imask;
    } sr_fields_t;

    localparam int SR_W        = 32;
    localparam int SR_MD_BIT   = 30;
    localparam int SR_RB_BIT   = 29;
    localparam int SR_BL_BIT   = 28;
    localparam int SR_FD_BIT   = 15;
    localparam int SR_IMASK_LO = 4;

    localparam sr_fields_t SR_ENTRY = '{md: 1'b1, rb: 1'b1, bl: 1'b1,
                                        fd: 1'b0, imask: 4'hF};

    function automatic logic [SR_W-1:0] pack_sr(input sr_fields_t f);
        logic [SR_W-1:0] w;
        w = '0;
        w[SR_MD_BIT] = f.md;
        w[SR_RB_BIT] = f.rb;
        w[SR_BL_BIT] = f.bl;
        w[SR_FD_BIT] = f.fd;
        w[SR_IMASK_LO +: 4] = f.imask;
        return w;
    endfunction

endpackage

// File: rtl/rst_sync_chain.sv
module rst_sync_chain #(
    parameter int               WIDTH   = 2,
    parameter int               STAGES  = 2,
    parameter logic [WIDTH-1:0] RST_VAL = '0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] async_i,
    output logic [WIDTH-1:0] sync_o
);

    localparam int LAST = STAGES - 1;

    logic [WIDTH-1:0] stage_d [STAGES];
    logic [WIDTH-1:0] stage_q [STAGES];

    generate
        for (genvar s = 0; s < STAGES; s++) begin : g_stage
            if (s == 0) begin : g_first
                always_comb stage_d[s] = async_i;
            end else begin : g_rest
                always_comb stage_d[s] = stage_q[s-1];
            end

            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) stage_q[s] <= RST_VAL;
                else        stage_q[s] <= stage_d[s];
            end
        end
    endgenerate

    assign sync_o = stage_q[LAST];

endmodule

// File: rtl/rst_cause_dec.sv
module rst_cause_dec (
    input  logic rst_s_n,
    input  logic md_s,
    input  logic wdt_ovf,
    input  logic wdt_mode,
    input  logic wdt_rst_sel,
    output logic por_req,
    output logic man_req,
    output logic man_pin
);

    logic pin_por;
    logic wdt_por;
    logic wdt_man;

    always_comb begin
        pin_por = !rst_s_n &&  md_s;
        man_pin = !rst_s_n && !md_s;
        wdt_por = wdt_ovf && wdt_mode && !wdt_rst_sel;
        wdt_man = wdt_ovf && wdt_mode &&  wdt_rst_sel;
        por_req = pin_por || wdt_por;
        man_req = man_pin || wdt_man;
    end

endmodule

// File: rtl/rst_entry_seq.sv
module rst_entry_seq
    import rst_entry_pkg::*;
#(
    parameter int          XLEN       = 32,
    parameter logic [31:0] VEC_ADDR   = 32'hA000_0000,
    parameter logic [11:0] EVT_CODE   = 12'h000,
    parameter logic [31:0] VBR_ENTRY  = 32'h0000_0000
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            por_req,
    input  logic            man_req,
    input  logic            man_pin,
    output logic [XLEN-1:0] expevt_o,
    output logic [XLEN-1:0] vbr_o,
    output logic [SR_W-1:0] sr_o,
    output logic [XLEN-1:0] pc_o,
    output logic            reset_active_o,
    output logic            periph_init_o,
    output logic            reset_done_o,
    output logic            fetch_en_o,
    output logic            man_rst_o,
    output logic            unsup_seq_o
);

    localparam int EVT_W = 12;

    typedef struct packed {
        rst_state_e      st;
        logic            fetch_en;
        logic            unsup;
        logic [XLEN-1:0] expevt;
        logic [XLEN-1:0] vbr;
        logic [SR_W-1:0] sr;
        logic [XLEN-1:0] pc;
    } seq_state_t;

    seq_state_t state_d, state_q;

    always_comb begin
        state_d = state_q;
        case (state_q.st)
            ST_RUN, ST_MAN: begin
                if (por_req) begin
                    state_d.st       = ST_POR;
                    state_d.fetch_en = 1'b0;
                    state_d.unsup    = 1'b0;
                end else if (man_req) begin
                    state_d.st       = ST_MAN;
                    state_d.fetch_en = 1'b0;
                end else begin
                    state_d.st       = ST_RUN;
                end
            end
            ST_POR: begin
                if (!por_req) begin
                    state_d.st = ST_LOAD;
                    if (man_pin) state_d.unsup = 1'b1;
                end
            end
            ST_LOAD: begin
                state_d.st     = ST_DONE;
                state_d.expevt = XLEN'(EVT_CODE);
                state_d.vbr    = VBR_ENTRY;
                state_d.sr     = pack_sr(SR_ENTRY);
                state_d.pc     = VEC_ADDR;
            end
            ST_DONE: begin
                if (por_req) begin
                    state_d.st    = ST_POR;
                    state_d.unsup = 1'b0;
                end else begin
                    state_d.st       = ST_RUN;
                    state_d.fetch_en = 1'b1;
                end
            end
            default: state_d.st = ST_POR;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q          <= '0;
            state_q.st       <= ST_POR;
        end else begin
            state_q <= state_d;
        end
    end

    assign expevt_o       = state_q.expevt;
    assign vbr_o          = state_q.vbr;
    assign sr_o           = state_q.sr;
    assign pc_o           = state_q.pc;
    assign reset_active_o = (state_q.st == ST_POR) || (state_q.st == ST_LOAD);
    assign periph_init_o  = reset_active_o || (state_q.st == ST_DONE);
    assign reset_done_o   = (state_q.st == ST_DONE);
    assign fetch_en_o     = state_q.fetch_en;
    assign man_rst_o      = (state_q.st == ST_MAN);
    assign unsup_seq_o    = state_q.unsup;

    // R5: power-on wins over a simultaneous manual condition
    p_por_wins_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (por_req && man_req && state_q.st == ST_RUN) |=> (reset_active_o && !man_rst_o));

    // R6: one hold cycle after the request drops
    p_hold_after_release_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q.st == ST_POR && !por_req) |=> reset_active_o);

    // R7/R8: loaded values present when the strobe fires
    p_entry_values_r8: assert property (@(posedge clk) disable iff (!rst_n)
        reset_done_o |-> (sr_o == 32'h7000_00F0 && pc_o == VEC_ADDR
                          && expevt_o[EVT_W-1:0] == EVT_CODE && vbr_o == VBR_ENTRY));

    // R9: the strobe is one cycle wide and follows the hold cycle
    p_done_single_r9: assert property (@(posedge clk) disable iff (!rst_n)
        reset_done_o |=> !reset_done_o);

    p_done_after_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        reset_done_o |-> $past(reset_active_o));

    // R10: fetch opens only after the strobe and never during reset
    p_fetch_after_done_r10: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(fetch_en_o) |-> $past(reset_done_o));

    p_no_fetch_in_reset_r10: assert property (@(posedge clk) disable iff (!rst_n)
        reset_active_o |-> !fetch_en_o);

    // R11: peripheral initialise covers reset plus one cycle
    p_init_tail_r11: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(reset_active_o) |-> periph_init_o);

    // R12: unsupported sequence is flagged
    p_unsup_flag_r12: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q.st == ST_POR && !por_req && man_pin) |=> unsup_seq_o);

endmodule

// File: rtl/rst_entry_ctrl.sv
module rst_entry_ctrl
    import rst_entry_pkg::*;
#(
    parameter int          SYNC_STAGES = 2,
    parameter int          XLEN        = 32,
    parameter logic [31:0] VEC_ADDR    = 32'hA000_0000
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            rst_pin_n,
    input  logic            md_pin,
    input  logic            wdt_ovf,
    input  logic            wdt_mode,
    input  logic            wdt_rst_sel,
    output logic [XLEN-1:0] expevt_o,
    output logic [XLEN-1:0] vbr_o,
    output logic [SR_W-1:0] sr_o,
    output logic [XLEN-1:0] pc_o,
    output logic            reset_active_o,
    output logic            periph_init_o,
    output logic            reset_done_o,
    output logic            fetch_en_o,
    output logic            man_rst_o,
    output logic            unsup_seq_o
);

    localparam int PIN_W = 2;
    // bit 1: mode pin (idle high), bit 0: reset pin (held asserted until synced)
    localparam logic [PIN_W-1:0] PIN_RST_VAL = 2'b10;

    logic [PIN_W-1:0] pins_s;
    logic             por_req;
    logic             man_req;
    logic             man_pin;

    rst_sync_chain #(
        .WIDTH   (PIN_W),
        .STAGES  (SYNC_STAGES),
        .RST_VAL (PIN_RST_VAL)
    ) pin_sync_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .async_i ({md_pin, rst_pin_n}),
        .sync_o  (pins_s)
    );

    rst_cause_dec cause_i (
        .rst_s_n     (pins_s[0]),
        .md_s        (pins_s[1]),
        .wdt_ovf     (wdt_ovf),
        .wdt_mode    (wdt_mode),
        .wdt_rst_sel (wdt_rst_sel),
        .por_req     (por_req),
        .man_req     (man_req),
        .man_pin     (man_pin)
    );

    rst_entry_seq #(
        .XLEN     (XLEN),
        .VEC_ADDR (VEC_ADDR)
    ) seq_i (
        .clk            (clk),
        .rst_n          (rst_n),
        .por_req        (por_req),
        .man_req        (man_req),
        .man_pin        (man_pin),
        .expevt_o       (expevt_o),
        .vbr_o          (vbr_o),
        .sr_o           (sr_o),
        .pc_o           (pc_o),
        .reset_active_o (reset_active_o),
        .periph_init_o  (periph_init_o),
        .reset_done_o   (reset_done_o),
        .fetch_en_o     (fetch_en_o),
        .man_rst_o      (man_rst_o),
        .unsup_seq_o    (unsup_seq_o)
    );

    // R3: a watchdog pulse in interval mode never starts a reset
    p_wdt_interval_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (wdt_ovf && !wdt_mode && pins_s[0] && !reset_active_o && !man_rst_o)
        |=> (!reset_active_o && !man_rst_o));

    // R4: manual condition never shows as power-on reset
    p_manual_not_por_r4: assert property (@(posedge clk) disable iff (!rst_n)
        man_rst_o |-> !reset_active_o);

endmodule

// File: tb/rst_entry_ctrl_tb_top.sv
module rst_entry_ctrl_tb_top;

    typedef struct {
        logic [31:0] expevt;
        logic [31:0] vbr;
        logic [31:0] sr;
        logic [31:0] pc;
    } entry_t;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        rst_pin_n = 1'b1;
    logic        md_pin = 1'b1;
    logic        wdt_ovf = 1'b0;
    logic        wdt_mode = 1'b0;
    logic        wdt_rst_sel = 1'b0;
    logic [31:0] expevt_o, vbr_o, sr_o, pc_o;
    logic        reset_active_o, periph_init_o, reset_done_o;
    logic        fetch_en_o, man_rst_o, unsup_seq_o;

    int     checks = 0;
    int     errors = 0;
    bit     finished = 0;
    entry_t exp_q[$];

    always #2 clk = ~clk;  // 250 MHz

    rst_entry_ctrl dut_i (
        .clk(clk), .rst_n(rst_n), .rst_pin_n(rst_pin_n), .md_pin(md_pin),
        .wdt_ovf(wdt_ovf), .wdt_mode(wdt_mode), .wdt_rst_sel(wdt_rst_sel),
        .expevt_o(expevt_o), .vbr_o(vbr_o), .sr_o(sr_o), .pc_o(pc_o),
        .reset_active_o(reset_active_o), .periph_init_o(periph_init_o),
        .reset_done_o(reset_done_o), .fetch_en_o(fetch_en_o),
        .man_rst_o(man_rst_o), .unsup_seq_o(unsup_seq_o)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic cyc(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    // driver side of the scoreboard: expected loaded state per entry
    task automatic push_entry();
        entry_t e;
        e.expevt = 32'h0000_0000;
        e.vbr    = 32'h0000_0000;
        e.sr     = (32'h1 << 30) | (32'h1 << 29) | (32'h1 << 28) | (32'hF << 4);
        e.pc     = 32'hA000_0000;
        exp_q.push_back(e);
    endtask

    // monitor side: every completion strobe pops one expected item
    always @(negedge clk) begin
        if (rst_n && reset_done_o) begin
            if (exp_q.size() == 0) begin
                check("R9 unexpected entry", 32'h1, 32'h0);
            end else begin
                entry_t e;
                e = exp_q.pop_front();
                check("R7 expevt", expevt_o, e.expevt);
                check("R7 vbr", vbr_o, e.vbr);
                check("R7 pc", pc_o, e.pc);
                check("R8 sr", sr_o, e.sr);
                check("R11 init at done", {31'b0, periph_init_o}, 32'h1);
                check("R6 active off at done", {31'b0, reset_active_o}, 32'h0);
            end
        end
    end

    initial begin
        for (int i = 0; i < 20000 && !finished; i++) @(posedge clk);
        if (!finished) begin
            errors++;
            checks++;
            $display("FAIL watchdog timeout actual=running expected=finished");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        // R13: reset state
        cyc(2);
        check("R13 active in reset", {31'b0, reset_active_o}, 32'h1);
        check("R13 fetch off", {31'b0, fetch_en_o}, 32'h0);
        check("R13 sr zero", sr_o, 32'h0);
        check("R13 pc zero", pc_o, 32'h0);
        push_entry();
        rst_n = 1'b1;
        cyc(6);
        check("R13 self entry completes", {31'b0, fetch_en_o}, 32'h1);
        check("R13 queue drained", exp_q.size(), 32'h0);

        // R1/R2/R6/R9/R10/R11: pin power-on reset
        rst_pin_n = 1'b0;
        md_pin    = 1'b1;
        cyc(2);
        check("R1 no effect after two edges", {31'b0, reset_active_o}, 32'h0);
        cyc(1);
        check("R1 R2 active after three edges", {31'b0, reset_active_o}, 32'h1);
        check("R10 fetch off in reset", {31'b0, fetch_en_o}, 32'h0);
        check("R11 init during reset", {31'b0, periph_init_o}, 32'h1);
        cyc(4);
        check("R2 still active while pin low", {31'b0, reset_active_o}, 32'h1);
        push_entry();
        rst_pin_n = 1'b1;
        cyc(3);
        check("R6 hold cycle active", {31'b0, reset_active_o}, 32'h1);
        check("R9 no strobe in hold", {31'b0, reset_done_o}, 32'h0);
        cyc(1);
        check("R9 strobe after hold", {31'b0, reset_done_o}, 32'h1);
        check("R10 fetch still off at strobe", {31'b0, fetch_en_o}, 32'h0);
        cyc(1);
        check("R9 strobe single cycle", {31'b0, reset_done_o}, 32'h0);
        check("R11 init ends", {31'b0, periph_init_o}, 32'h0);
        check("R10 fetch opens", {31'b0, fetch_en_o}, 32'h1);
        check("R12 flag clear", {31'b0, unsup_seq_o}, 32'h0);

        // R3: watchdog in interval mode is ignored
        wdt_mode = 1'b0; wdt_rst_sel = 1'b0;
        cyc(1);
        wdt_ovf = 1'b1; cyc(1); wdt_ovf = 1'b0;
        check("R3 interval no reset", {31'b0, reset_active_o}, 32'h0);
        check("R3 interval no manual", {31'b0, man_rst_o}, 32'h0);
        cyc(3);
        check("R3 interval fetch kept", {31'b0, fetch_en_o}, 32'h1);

        // R3: watchdog power-on type
        wdt_mode = 1'b1; wdt_rst_sel = 1'b0;
        push_entry();
        cyc(1);
        wdt_ovf = 1'b1; cyc(1); wdt_ovf = 1'b0;
        check("R3 wdt power-on active", {31'b0, reset_active_o}, 32'h1);
        cyc(5);
        check("R3 wdt entry done", exp_q.size(), 32'h0);
        check("R10 fetch after wdt entry", {31'b0, fetch_en_o}, 32'h1);

        // R3/R4: watchdog manual type
        wdt_rst_sel = 1'b1;
        cyc(1);
        wdt_ovf = 1'b1; cyc(1); wdt_ovf = 1'b0;
        check("R3 R4 wdt manual flagged", {31'b0, man_rst_o}, 32'h1);
        check("R4 manual not power-on", {31'b0, reset_active_o}, 32'h0);
        check("R4 manual stops fetch", {31'b0, fetch_en_o}, 32'h0);
        cyc(1);
        check("R4 manual pulse ends", {31'b0, man_rst_o}, 32'h0);

        // R4: manual pin combination
        rst_pin_n = 1'b0; md_pin = 1'b0;
        cyc(4);
        check("R4 pin manual", {31'b0, man_rst_o}, 32'h1);
        check("R4 pin manual no por", {31'b0, reset_active_o}, 32'h0);
        rst_pin_n = 1'b1; md_pin = 1'b1;
        cyc(4);
        check("R4 manual released", {31'b0, man_rst_o}, 32'h0);

        // R5: watchdog power-on arrives with manual pins in the same cycle
        wdt_rst_sel = 1'b0;
        rst_pin_n = 1'b0; md_pin = 1'b0;
        cyc(2);
        push_entry();
        wdt_ovf = 1'b1; cyc(1); wdt_ovf = 1'b0;
        check("R5 power-on wins", {31'b0, reset_active_o}, 32'h1);
        check("R5 manual suppressed", {31'b0, man_rst_o}, 32'h0);
        rst_pin_n = 1'b1; md_pin = 1'b1;
        cyc(8);
        check("R5 entry completed", exp_q.size(), 32'h0);

        // R12: mode pin falls while reset pin low during power-on
        rst_pin_n = 1'b0; md_pin = 1'b1;
        cyc(5);
        check("R12 new entry clears flag", {31'b0, unsup_seq_o}, 32'h0);
        push_entry();
        md_pin = 1'b0;
        cyc(6);
        check("R12 flag set", {31'b0, unsup_seq_o}, 32'h1);
        check("R12 manual follows", {31'b0, man_rst_o}, 32'h1);
        rst_pin_n = 1'b1; md_pin = 1'b1;
        cyc(5);
        check("R12 flag sticky", {31'b0, unsup_seq_o}, 32'h1);
        push_entry();
        wdt_ovf = 1'b1; cyc(1); wdt_ovf = 1'b0;
        check("R12 cleared on next entry", {31'b0, unsup_seq_o}, 32'h0);
        cyc(6);
        check("R9 all entries seen", exp_q.size(), 32'h0);

        finished = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule